// File: doc/BRIEF.md
# ARX Block Cipher Round Unit

This block evaluates a single round of a 128-bit add-rotate-xor block cipher, in either the forward direction or its exact inverse. A 128-bit state made of four 32-bit words and a 192-bit round key made of six 32-bit words enter together with a direction bit. The result is the following state when encrypting, or the preceding state when decrypting.

The unit has no registers. A surrounding sequencer chains it across rounds, supplies round keys in forward or reverse order, and holds the state between rounds. Word 0 of the state sits in bits [127:96] and word 3 in bits [31:0]. Key word k0 sits in bits [191:160] and k5 in bits [31:0].

Top module: `lea_round`

## Requirements
- R1: With decrypt_i = 0, word 3 of state_o equals word 0 of state_i.
- R2: With decrypt_i = 0, word 0 of state_o equals ((w0 ^ k0) + (w1 ^ k1)) mod 2^32, rotated left by 9.
- R3: With decrypt_i = 0, word 1 of state_o equals ((w1 ^ k2) + (w2 ^ k3)) mod 2^32, rotated right by 5.
- R4: With decrypt_i = 0, word 2 of state_o equals ((w2 ^ k4) + (w3 ^ k5)) mod 2^32, rotated right by 3.
- R5: With decrypt_i = 1 and input words y0..y3, word 0 of state_o (p0) equals y3.
- R6: With decrypt_i = 1, the remaining words are recovered in sequence. p1 = (ROR9(y0) - (p0 ^ k0)) ^ k1, then p2 = (ROL5(y1) - (p1 ^ k2)) ^ k3, then p3 = (ROL3(y2) - (p2 ^ k4)) ^ k5, all mod 2^32.
- R7: Decrypting the encrypt result with the same round key returns the original state for any state and key.
- R8: The output is a pure function of the present inputs. Changing decrypt_i alone switches state_o between the two results with no clock.
- R9: Carries out of bit 31 in the additions are discarded, and borrows in the subtractions wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| state_i | input | 128 | Round input state, word 0 in the top bits |
| round_key_i | input | 192 | Round key, k0 in the top bits |
| decrypt_i | input | 1 | 0 = forward round, 1 = inverse round |
| state_o | output | 128 | Round output state, same word packing |

## Verification
The bench builds the unit with its default rotation amounts of 9, 27 and 29 left, which are the forward rotations the requirements name. With these defaults, hand-derived vectors can exercise a dropped carry, a wrapped borrow and a key word that cancels its data word. Table vectors then cover both directions against a reference model and a round trip through both directions.

// File: rtl/lea_round_pkg.sv
package lea_round_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned N_WORDS = 4;
  localparam int unsigned N_KEYS  = 2 * (N_WORDS - 1);
  localparam int unsigned N_LANES = N_WORDS - 1;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotl(word_t x, int unsigned n);
    int unsigned s;
    s = n % WORD_W;
    if (s == 0) return x;
    return (x << s) | (x >> (WORD_W - s));
  endfunction

  function automatic word_t rotr(word_t x, int unsigned n);
    return rotl(x, WORD_W - (n % WORD_W));
  endfunction
endpackage

// File: rtl/lea_round_fwd.sv
module lea_round_fwd
  import lea_round_pkg::*;
#(
  parameter int unsigned ROT0 = 9,
  parameter int unsigned ROT1 = 27,
  parameter int unsigned ROT2 = 29
) (
  input  word_t words_i [N_WORDS],
  input  word_t key_i   [N_KEYS],
  output word_t words_o [N_WORDS]
);
  localparam int unsigned ROT [N_LANES] = '{ROT0, ROT1, ROT2};

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    word_t lhs, rhs, mix;
    assign lhs = words_i[g]   ^ key_i[2*g];
    assign rhs = words_i[g+1] ^ key_i[2*g+1];
    assign mix = lhs + rhs;  // carry out of the top bit is dropped
    assign words_o[g] = rotl(mix, ROT[g]);

    // undo the lane from its output and the left neighbour; must give the right neighbour back
    if (g == 0) begin : g_a0
      always_comb
        assert_fwd_lane0_R2: assert (((rotr(words_o[g], ROT[g]) - lhs) ^ key_i[2*g+1]) == words_i[g+1])
          else $error("lane 0 not invertible");
    end else if (g == 1) begin : g_a1
      always_comb
        assert_fwd_lane1_R3: assert (((rotr(words_o[g], ROT[g]) - lhs) ^ key_i[2*g+1]) == words_i[g+1])
          else $error("lane 1 not invertible");
    end else begin : g_a2
      always_comb
        assert_fwd_lane2_R4: assert (((rotr(words_o[g], ROT[g]) - lhs) ^ key_i[2*g+1]) == words_i[g+1])
          else $error("lane 2 not invertible");
    end
  end

  assign words_o[N_WORDS-1] = words_i[0];
endmodule

// File: rtl/lea_round_inv.sv
module lea_round_inv
  import lea_round_pkg::*;
#(
  parameter int unsigned ROT0 = 9,
  parameter int unsigned ROT1 = 27,
  parameter int unsigned ROT2 = 29
) (
  input  word_t words_i [N_WORDS],
  input  word_t key_i   [N_KEYS],
  output word_t words_o [N_WORDS]
);
  localparam int unsigned ROT [N_LANES] = '{ROT0, ROT1, ROT2};

  // recovered word 0 is the old first word; each later word depends on the one before
  assign words_o[0] = words_i[N_WORDS-1];

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    word_t unrot, lhs, diff;
    assign unrot = rotr(words_i[g], ROT[g]);
    assign lhs   = words_o[g] ^ key_i[2*g];
    assign diff  = unrot - lhs;  // borrow wraps
    assign words_o[g+1] = diff ^ key_i[2*g+1];

    // re-running the forward lane on the recovered pair must reproduce the input word
    always_comb
      assert_inv_relane_R6: assert (rotl((words_o[g] ^ key_i[2*g]) + (words_o[g+1] ^ key_i[2*g+1]), ROT[g]) == words_i[g])
        else $error("inverse lane %0d inconsistent", g);
  end
endmodule

// File: rtl/lea_round.sv
module lea_round
  import lea_round_pkg::*;
#(
  parameter int unsigned ROT0 = 9,
  parameter int unsigned ROT1 = 27,
  parameter int unsigned ROT2 = 29,
  localparam int unsigned STATE_W = N_WORDS * WORD_W,
  localparam int unsigned KEY_W   = N_KEYS * WORD_W
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic [KEY_W-1:0]   round_key_i,
  input  logic               decrypt_i,
  output logic [STATE_W-1:0] state_o
);
  word_t in_w  [N_WORDS];
  word_t key_w [N_KEYS];
  word_t fwd_w [N_WORDS];
  word_t inv_w [N_WORDS];
  word_t out_w [N_WORDS];

  for (genvar i = 0; i < N_WORDS; i++) begin : g_unpack_s
    assign in_w[i] = state_i[(N_WORDS-1-i)*WORD_W +: WORD_W];
  end
  for (genvar i = 0; i < N_KEYS; i++) begin : g_unpack_k
    assign key_w[i] = round_key_i[(N_KEYS-1-i)*WORD_W +: WORD_W];
  end

  lea_round_fwd #(.ROT0(ROT0), .ROT1(ROT1), .ROT2(ROT2)) u_fwd (
    .words_i(in_w), .key_i(key_w), .words_o(fwd_w)
  );

  lea_round_inv #(.ROT0(ROT0), .ROT1(ROT1), .ROT2(ROT2)) u_inv (
    .words_i(in_w), .key_i(key_w), .words_o(inv_w)
  );

  for (genvar i = 0; i < N_WORDS; i++) begin : g_pack
    assign out_w[i] = decrypt_i ? inv_w[i] : fwd_w[i];
    assign state_o[(N_WORDS-1-i)*WORD_W +: WORD_W] = out_w[i];
  end

  always_comb begin
    if (!decrypt_i)
      assert_fwd_wrap_R1: assert (state_o[WORD_W-1:0] == state_i[STATE_W-1 -: WORD_W])
        else $error("forward word rotation wrong");
    else
      assert_inv_wrap_R5: assert (state_o[STATE_W-1 -: WORD_W] == state_i[WORD_W-1:0])
        else $error("inverse word rotation wrong");
  end
endmodule

// File: tb/lea_round_test.sv
module lea_round_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [127:0] state_i;
  logic [191:0] round_key_i;
  logic         decrypt_i;
  logic [127:0] state_o;

  lea_round uut (
    .state_i(state_i), .round_key_i(round_key_i),
    .decrypt_i(decrypt_i), .state_o(state_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  localparam int N_TAB = 6;
  localparam logic [127:0] TAB_S [N_TAB] = '{
    128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
    128'hffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff,
    128'h8000_0000_7fff_ffff_0000_0001_dead_beef,
    128'h1357_9bdf_2468_ace0_0f0f_f0f0_a5a5_5a5a,
    128'h0000_0000_0000_0000_0000_0000_0000_0000,
    128'hcafe_f00d_1234_5678_9abc_def0_0bad_c0de
  };
  localparam logic [191:0] TAB_K [N_TAB] = '{
    192'h0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0_1122_3344_5566_7788,
    192'h0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000,
    192'hc3ef_e9db_4462_6b02_79e2_7c8a_78df_30ec_715e_a49e_c785_da0a,
    192'hffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff,
    192'h0123_4567_89ab_cdef_0011_2233_4455_6677_8899_aabb_ccdd_eeff,
    192'h9e37_79b9_7f4a_7c15_f39c_c060_5ced_c834_1082_276b_f3a2_7251
  };

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction
  function automatic logic [31:0] rr(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [127:0] model_enc(logic [127:0] s, logic [191:0] k);
    logic [31:0] a, b, c, d;
    logic [31:0] kk [6];
    {a, b, c, d} = s;
    {kk[0], kk[1], kk[2], kk[3], kk[4], kk[5]} = k;
    return {rl((a ^ kk[0]) + (b ^ kk[1]), 9),
            rr((b ^ kk[2]) + (c ^ kk[3]), 5),
            rr((c ^ kk[4]) + (d ^ kk[5]), 3), a};
  endfunction

  function automatic logic [127:0] model_dec(logic [127:0] s, logic [191:0] k);
    logic [31:0] y0, y1, y2, y3, p0, p1, p2, p3;
    logic [31:0] kk [6];
    {y0, y1, y2, y3} = s;
    {kk[0], kk[1], kk[2], kk[3], kk[4], kk[5]} = k;
    p0 = y3;
    p1 = (rr(y0, 9) - (p0 ^ kk[0])) ^ kk[1];
    p2 = (rl(y1, 5) - (p1 ^ kk[2])) ^ kk[3];
    p3 = (rl(y2, 3) - (p2 ^ kk[4])) ^ kk[5];
    return {p0, p1, p2, p3};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [127:0] s, logic [191:0] k, logic d);
    @(negedge clk);
    state_i = s; round_key_i = k; decrypt_i = d;
    #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] e, exp;
    state_i = '0; round_key_i = '0; decrypt_i = 1'b0;

    // all-zero inputs give all-zero output in both directions (R8)
    apply('0, '0, 1'b0);
    check("R8 zero fwd", state_o, '0);
    apply('0, '0, 1'b1);
    check("R8 zero inv", state_o, '0);

    for (int i = 0; i < N_TAB; i++) begin
      exp = model_enc(TAB_S[i], TAB_K[i]);
      apply(TAB_S[i], TAB_K[i], 1'b0);
      e = state_o;
      check("R2 word0", {e[127:96], 96'h0}, {exp[127:96], 96'h0});
      check("R3 word1", {32'h0, e[95:64], 64'h0}, {32'h0, exp[95:64], 64'h0});
      check("R4 word2", {64'h0, e[63:32], 32'h0}, {64'h0, exp[63:32], 32'h0});
      check("R1 word3", {96'h0, e[31:0]}, {96'h0, TAB_S[i][127:96]});
      // same inputs, only decrypt_i flips (R8)
      decrypt_i = 1'b1; #1;
      check("R8 mode flip", state_o, model_dec(TAB_S[i], TAB_K[i]));
      check("R5 first word", {state_o[127:96], 96'h0}, {TAB_S[i][31:0], 96'h0});
      check("R6 inverse", state_o, model_dec(TAB_S[i], TAB_K[i]));
      apply(e, TAB_K[i], 1'b1);
      check("R7 round trip", state_o, TAB_S[i]);
    end

    // dropped carries (R9): 0x80000000 + 0x80000000 = 0
    apply(128'h8000_0000_8000_0000_0000_0000_0000_0008, '0, 1'b0);
    check("R9 carry drop", state_o, 128'h0000_0000_0400_0000_0000_0001_8000_0000);
    // wrapped borrow on the way back (R9, R6)
    apply(128'h0000_0000_0400_0000_0000_0001_8000_0000, '0, 1'b1);
    check("R9 borrow wrap", state_o, 128'h8000_0000_8000_0000_0000_0000_0000_0008);
    // rotation position of lane 0 (R2): 1 rotated left by 9
    apply(128'h0000_0001_0000_0000_0000_0000_0000_0000, '0, 1'b0);
    check("R2 rot9", state_o, 128'h0000_0200_0000_0000_0000_0000_0000_0001);
    // key word k0 cancels w0 (R2)
    apply(128'h0000_0005_0000_0000_0000_0000_0000_0000,
          192'h0000_0005_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000, 1'b0);
    check("R2 key cancel", state_o, 128'h0000_0000_0000_0000_0000_0000_0000_0005);
    // k5 lands on word 3 only (R4): (0 ^ 0) + (0 ^ 0x18) = 0x18, ror3 = 3
    apply('0, 192'h18, 1'b0);
    check("R4 k5 lane", state_o, 128'h0000_0000_0000_0000_0000_0003_0000_0000);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule